// File: doc/BRIEF.md
# Power Management Event Controller

This block decides, for a PC-style chipset, which hardware activity keeps the platform awake and which activity brings it back from a powered-down state. Twenty activity inputs feed it: sixteen IRQ lines plus NMI, an external SMI pin, an APIC interrupt and INTR. Each input is synchronized to the block clock and reduced to a rising-edge event, so a line that stays high counts once.

The inputs reach two separate paths. On the **keep-awake path**, an enabled event reloads a down-counting idle timer with its programmed initial count. On the **wake-up path**, an enabled event, while the platform is powered down, negates the active-low stop-clock output.

An 8-bit SMI-source enable register picks which conditions raise a level SMI request:

- an APM control port write strobe,
- the external SMI pin,
- the idle timer reaching zero,
- five specific IRQ lines.

Software clears each latched SMI cause with a write of one.

Software enters powerdown by writing a request bit. The block then holds stop-clock low until a wake event arrives. All state is reached through a 4-word register port:

| Word | Contents |
|------|----------|
| 0 | Event enables |
| 1 | SMI-source enables |
| 2 | Timer initial count |
| 3 | Control/status |

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, words 0, 1, 2 and 3 read 0, `stpclk_n` is 1 and `smi_req` is 0.
- R2: The event enable word (word 0) keeps only bits 31:28, 15:3 and 1:0. Writes to bits 27:16 and bit 2 are ignored, and those bits read back 0, so writing all ones reads back 0xF000FFFB.
- R3: A rising edge on an input enabled as a keep-awake event reloads the idle timer with the value last written to word 2. The word 0 enables for this path are:
  - bit n for IRQn (n = 0, 1, 3..15),
  - bit 29 for NMI,
  - bit 31 for the SMI pin.
  
  A rising edge on a disabled input leaves the count unchanged.
- R4: A write to word 2 loads both the initial count and the timer. The timer falls by one on each clock with `tick_en` high and stops at zero. Its value reads back in word 3 bits 31:16.
- R5: `stpclk_n` goes low only on a write to word 3 with bit 0 set. Writing 0 to bit 0 has no effect.
- R6: While powered down, any keep-awake event or an APIC rising edge enabled by word 0 bit 28 raises `stpclk_n`. The APIC path does not reload the timer, and a disabled input leaves the platform powered down.
- R7: With word 0 bit 30 set, a rising edge on INTR or on any IRQ line wakes the platform whatever the per-IRQ bits hold, without reloading the timer. With bit 30 clear, a disabled IRQ does not wake it.
- R8: A held-high input yields a single event. It neither reloads the timer again nor sets a cleared SMI cause again.
- R9: With SMI-source bit 5 set, the timer stepping from 1 to 0 sets status bit 5 (word 3 bit 13) and raises `smi_req`. With bit 5 clear, expiry raises nothing.
- R10: The other SMI sources each set their own status bit when enabled, and a source whose enable is clear sets nothing. The bit mapping is:

  | SMI-source bit | Source |
  |----------------|--------|
  | 7 | `apm_wr_stb` |
  | 6 | SMI pin |
  | 4 | IRQ12 |
  | 3 | IRQ8 |
  | 2 | IRQ4 |
  | 1 | IRQ3 |
  | 0 | IRQ1 |

  Status bit k reads at word 3 bit 8+k.
- R11: `smi_req` is the OR of the status bits and stays high until software writes one to each set bit at word 3 bits 15:8. Writing zeros clears nothing.
- R12: An activity input's effect on timer, `stpclk_n` and status appears on the third rising clock edge after the input changes, not the second. Read data appears one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_in | input | 16 | Asynchronous IRQ activity lines |
| nmi_in | input | 1 | Asynchronous NMI activity |
| smi_pin_in | input | 1 | Asynchronous external SMI pin, active high |
| apic_in | input | 1 | Asynchronous APIC interrupt activity |
| intr_in | input | 1 | Asynchronous INTR activity |
| apm_wr_stb | input | 1 | Synchronous one-cycle APM control port write strobe |
| tick_en | input | 1 | Idle timer decrement enable |
| stpclk_n | output | 1 | Stop-clock request, active low |
| smi_req | output | 1 | SMI request level |

## Verification
Latencies differ by cause:

| Cause | Effect seen on |
|-------|----------------|
| Asynchronous activity input | Third rising edge after it changes (two synchronizer stages, then a registered action) |
| `apm_wr_stb` | First edge |
| Register write | Edge of the write itself |
| Read data | One edge after the address |
| Timer expiry status | Same edge the count reaches zero |

The bench drives every input on the falling edge and waits the matching number of falling edges before sampling. Counts are read only while `tick_en` is low, so the value cannot move between the event and the read.

One check on the APIC path samples `stpclk_n` one cycle early and expects it still low. This pins the three-edge latency rather than merely tolerating it.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
  localparam int NUM_IRQ    = 16;
  localparam int ACT_W      = NUM_IRQ + 4;
  localparam int SMI_SRC_W  = 8;

  // event enable word: kept bit positions
  localparam logic [31:0] EV_KEEP_MASK = 32'hF000_FFFB;
  localparam int EV_SMI  = 31;
  localparam int EV_INTR = 30;
  localparam int EV_NMI  = 29;
  localparam int EV_APIC = 28;

  // register word select
  localparam logic [1:0] W_EVEN   = 2'd0;
  localparam logic [1:0] W_SMIEN  = 2'd1;
  localparam logic [1:0] W_RELOAD = 2'd2;
  localparam logic [1:0] W_CTRL   = 2'd3;

  // SMI source bit positions
  localparam int S_APM  = 7;
  localparam int S_PIN  = 6;
  localparam int S_TMR  = 5;

  typedef struct packed {
    logic                 intr;
    logic                 apic;
    logic                 nmi;
    logic                 smi;
    logic [NUM_IRQ-1:0]   irq;
  } act_t;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int W      = 20,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], d[g]};
        prev <= sh[STAGES-1];
      end
    end

    assign rise[g] = sh[STAGES-1] & ~prev;

    // R8: an edge event lasts exactly one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - ONE;
  end

  assign expire = tick & ~load & (cnt == ONE);

  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  a_r4_floor: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> cnt == '0);
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt != '0) |=> cnt == $past(cnt) - ONE);
  a_r9_expire_zero: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == '0);
endmodule

// File: rtl/pm_event_route.sv
module pm_event_route
  import pm_event_pkg::*;
(
  input  act_t                  rise,
  input  logic [31:0]           ev_en,
  input  logic [SMI_SRC_W-1:0]  smi_en,
  input  logic                  apm_stb,
  input  logic                  tmr_expire,
  output logic                  keep_awake,
  output logic                  wake,
  output logic [SMI_SRC_W-1:0]  smi_set
);
  logic [NUM_IRQ-1:0]   irq_en;
  logic [SMI_SRC_W-1:0] smi_raw;

  always_comb begin
    irq_en     = ev_en[NUM_IRQ-1:0] & EV_KEEP_MASK[NUM_IRQ-1:0];
    keep_awake = (|(rise.irq & irq_en))
               | (ev_en[EV_SMI] & rise.smi)
               | (ev_en[EV_NMI] & rise.nmi);
    wake       = keep_awake
               | (ev_en[EV_APIC] & rise.apic)
               | (ev_en[EV_INTR] & ((|rise.irq) | rise.intr));
    smi_raw    = {apm_stb, rise.smi, tmr_expire,
                  rise.irq[12], rise.irq[8], rise.irq[4], rise.irq[3], rise.irq[1]};
    smi_set    = smi_raw & smi_en;
  end
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_event_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [15:0] irq_in,
  input  logic        nmi_in,
  input  logic        smi_pin_in,
  input  logic        apic_in,
  input  logic        intr_in,
  input  logic        apm_wr_stb,
  input  logic        tick_en,
  output logic        stpclk_n,
  output logic        smi_req
);
  logic [31:0]           ev_en_q;
  logic [SMI_SRC_W-1:0]  smi_en_q;
  logic [TMR_W-1:0]      reload_q;
  logic [SMI_SRC_W-1:0]  status_q;
  logic                  asleep_q;

  act_t                  act_in;
  act_t                  act_rise;
  logic                  keep_awake, wake, tmr_expire;
  logic [SMI_SRC_W-1:0]  smi_set, smi_clr;
  logic [TMR_W-1:0]      cnt;
  logic                  wr_even, wr_smien, wr_reload, wr_ctrl;
  logic                  tmr_load;
  logic [TMR_W-1:0]      tmr_load_val;
  logic [15:0]           cnt_view;

  assign act_in = '{intr: intr_in, apic: apic_in, nmi: nmi_in,
                    smi: smi_pin_in, irq: irq_in};

  pm_edge_sync #(.W(ACT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(act_in), .rise(act_rise));

  pm_event_route u_route (
    .rise(act_rise), .ev_en(ev_en_q), .smi_en(smi_en_q),
    .apm_stb(apm_wr_stb), .tmr_expire(tmr_expire),
    .keep_awake(keep_awake), .wake(wake), .smi_set(smi_set));

  assign wr_even   = reg_wr && reg_addr == W_EVEN;
  assign wr_smien  = reg_wr && reg_addr == W_SMIEN;
  assign wr_reload = reg_wr && reg_addr == W_RELOAD;
  assign wr_ctrl   = reg_wr && reg_addr == W_CTRL;

  assign tmr_load     = wr_reload | keep_awake;
  assign tmr_load_val = wr_reload ? reg_wdata[TMR_W-1:0] : reload_q;

  pm_idle_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_load_val),
    .tick(tick_en), .cnt(cnt), .expire(tmr_expire));

  assign smi_clr  = wr_ctrl ? reg_wdata[8 +: SMI_SRC_W] : '0;
  assign cnt_view = 16'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_en_q   <= '0;
      smi_en_q  <= '0;
      reload_q  <= '0;
      status_q  <= '0;
      asleep_q  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_even)   ev_en_q  <= reg_wdata & EV_KEEP_MASK;
      if (wr_smien)  smi_en_q <= reg_wdata[SMI_SRC_W-1:0];
      if (wr_reload) reload_q <= reg_wdata[TMR_W-1:0];
      status_q <= (status_q & ~smi_clr) | smi_set;
      if (wake)                         asleep_q <= 1'b0;
      else if (wr_ctrl && reg_wdata[0]) asleep_q <= 1'b1;
      case (reg_addr)
        W_EVEN:   reg_rdata <= ev_en_q;
        W_SMIEN:  reg_rdata <= 32'(smi_en_q);
        W_RELOAD: reg_rdata <= 32'(reload_q);
        default:  reg_rdata <= {cnt_view, status_q, 7'd0, asleep_q};
      endcase
    end
  end

  assign stpclk_n = ~asleep_q;
  assign smi_req  = |status_q;

  a_r5_stop_needs_request: assert property (@(posedge clk) disable iff (rst)
    $fell(stpclk_n) |-> $past(wr_ctrl && reg_wdata[0]));
  a_r6_wake_release: assert property (@(posedge clk) disable iff (rst)
    (!stpclk_n && wake) |=> stpclk_n);
  a_r11_smi_hold: assert property (@(posedge clk) disable iff (rst)
    (smi_req && !wr_ctrl) |=> smi_req);
  a_r9_expiry_smi: assert property (@(posedge clk) disable iff (rst)
    (tmr_expire && smi_en_q[S_TMR]) |=> smi_req);
endmodule

// File: tb/pm_event_ctrl_tb_top.sv
module pm_event_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_in = '0;
  logic        nmi_in = 1'b0, smi_pin_in = 1'b0, apic_in = 1'b0, intr_in = 1'b0;
  logic        apm_wr_stb = 1'b0, tick_en = 1'b0;
  logic        stpclk_n, smi_req;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pm_event_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .nmi_in(nmi_in), .smi_pin_in(smi_pin_in), .apic_in(apic_in),
    .intr_in(intr_in), .apm_wr_stb(apm_wr_stb), .tick_en(tick_en),
    .stpclk_n(stpclk_n), .smi_req(smi_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd_cnt(output logic [31:0] c);
    logic [31:0] v;
    rd(2'd3, v); c = {16'd0, v[31:16]};
  endtask

  task automatic rd_stat(output logic [31:0] s);
    logic [31:0] v;
    rd(2'd3, v); s = {24'd0, v[15:8]};
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset word", v, 32'd0);
    end
    chk("R1 stpclk_n", {31'd0, stpclk_n}, 32'd1);
    chk("R1 smi_req", {31'd0, smi_req}, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 reserved bits", v, 32'hF000_FFFB);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_keep_awake();
    logic [31:0] v;
    wr(2'd0, (32'd1 << 5) | (32'd1 << 29) | (32'd1 << 31));
    wr(2'd2, 32'd100);
    rd_cnt(v); chk("R4 load via write", v, 32'd100);
    ticks(10); rd_cnt(v); chk("R4 decrement", v, 32'd90);
    @(negedge clk); irq_in[5] = 1'b1; wcyc(3);
    rd_cnt(v); chk("R3 IRQ5 reload", v, 32'd100);
    ticks(5); rd_cnt(v); chk("R8 held IRQ5 no second reload", v, 32'd95);
    @(negedge clk); irq_in[6] = 1'b1; wcyc(3);
    rd_cnt(v); chk("R3 disabled IRQ6 ignored", v, 32'd95);
    irq_in = '0; wcyc(3);
    @(negedge clk); nmi_in = 1'b1; wcyc(3);
    rd_cnt(v); chk("R3 NMI reload", v, 32'd100);
    nmi_in = 1'b0;
    ticks(4);
    @(negedge clk); smi_pin_in = 1'b1; wcyc(3);
    rd_cnt(v); chk("R3 SMI pin reload", v, 32'd100);
    chk("R10 SMI pin disabled source", {31'd0, smi_req}, 32'd0);
    smi_pin_in = 1'b0; wcyc(3);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(2'd0, 32'd0); wr(2'd1, 32'd0); wr(2'd2, 32'd3);
    ticks(6); rd_cnt(v); chk("R4 stop at zero", v, 32'd0);
    chk("R9 expiry disabled", {31'd0, smi_req}, 32'd0);
    wr(2'd1, 32'd1 << 5); wr(2'd2, 32'd2);
    ticks(3);
    chk("R9 expiry smi_req", {31'd0, smi_req}, 32'd1);
    rd_stat(v); chk("R9 status bit5", v, 32'h20);
    wcyc(5); chk("R11 level held", {31'd0, smi_req}, 32'd1);
    wr(2'd3, 32'd0); chk("R11 zero write keeps", {31'd0, smi_req}, 32'd1);
    wr(2'd3, 32'h2000); chk("R11 W1C clears", {31'd0, smi_req}, 32'd0);
  endtask

  task automatic t_powerdown();
    logic [31:0] v;
    wr(2'd0, 32'd1 << 28); wr(2'd2, 32'd50); ticks(5);
    chk("R5 awake before request", {31'd0, stpclk_n}, 32'd1);
    wr(2'd3, 32'd0); chk("R5 bit0 zero no effect", {31'd0, stpclk_n}, 32'd1);
    wr(2'd3, 32'd1); chk("R5 powerdown request", {31'd0, stpclk_n}, 32'd0);
    @(negedge clk); irq_in[5] = 1'b1; wcyc(3);
    chk("R6 disabled IRQ no wake", {31'd0, stpclk_n}, 32'd0);
    irq_in = '0;
    @(negedge clk); apic_in = 1'b1; wcyc(2);
    chk("R12 not yet at second edge", {31'd0, stpclk_n}, 32'd0);
    wcyc(1); chk("R6 APIC wake at third edge", {31'd0, stpclk_n}, 32'd1);
    rd_cnt(v); chk("R6 APIC no reload", v, 32'd45);
    apic_in = 1'b0; wcyc(3);
  endtask

  task automatic t_intr();
    logic [31:0] v;
    wr(2'd0, 32'd1 << 30); wr(2'd3, 32'd1);
    @(negedge clk); irq_in[9] = 1'b1; wcyc(3);
    chk("R7 any IRQ wakes", {31'd0, stpclk_n}, 32'd1);
    rd_cnt(v); chk("R7 no reload", v, 32'd45);
    irq_in = '0; wcyc(3);
    wr(2'd3, 32'd1);
    @(negedge clk); intr_in = 1'b1; wcyc(3);
    chk("R7 INTR wakes", {31'd0, stpclk_n}, 32'd1);
    intr_in = 1'b0; wcyc(3);
    wr(2'd0, 32'd0); wr(2'd3, 32'd1);
    @(negedge clk); irq_in[9] = 1'b1; wcyc(3);
    chk("R7 bit30 clear no wake", {31'd0, stpclk_n}, 32'd0);
    irq_in = '0;
    wr(2'd0, 32'd1 << 28);
    @(negedge clk); apic_in = 1'b1; wcyc(3); apic_in = 1'b0; wcyc(3);
  endtask

  task automatic t_smi_src();
    logic [31:0] v;
    wr(2'd0, 32'd0); wr(2'd1, 32'hD1);
    @(negedge clk); apm_wr_stb = 1'b1; @(negedge clk); apm_wr_stb = 1'b0;
    chk("R10 APM strobe smi_req", {31'd0, smi_req}, 32'd1);
    rd_stat(v); chk("R10 APM status", v, 32'h80);
    wr(2'd3, 32'h8000);
    @(negedge clk); smi_pin_in = 1'b1; wcyc(3);
    rd_stat(v); chk("R10 pin status", v, 32'h40);
    wr(2'd3, 32'h4000); smi_pin_in = 1'b0;
    @(negedge clk); irq_in[1] = 1'b1; wcyc(3);
    rd_stat(v); chk("R10 IRQ1 status", v, 32'h01);
    wr(2'd3, 32'h0100);
    @(negedge clk); irq_in[12] = 1'b1; wcyc(3);
    rd_stat(v); chk("R10 IRQ12 status", v, 32'h10);
    wr(2'd3, 32'h1000); wcyc(5);
    chk("R8 held IRQ12 no re-set", {31'd0, smi_req}, 32'd0);
    @(negedge clk); irq_in[8] = 1'b1; wcyc(3);
    chk("R10 IRQ8 disabled", {31'd0, smi_req}, 32'd0);
    irq_in = '0; wcyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wcyc(3); rst = 1'b0;
    t_reset();
    t_reserved();
    t_keep_awake();
    t_timer();
    t_powerdown();
    t_intr();
    t_smi_src();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule